// File: doc/BRIEF.md
# Multi-Class Pending Interrupt Queue

This block holds the floating interrupts that are waiting for a group of processors. I/O interrupts are sorted into eight subclasses. Each subclass keeps its entries in a small stack. An entry holds a subchannel id, a subchannel number, an interrupt parameter and an interrupt word. Two other kinds are kept beside the I/O stacks. A service signal has a pending flag and a parameter that collects the bits of every service injection. A machine-check/channel-report condition has a single pending flag.

A processor-side agent takes an I/O interrupt by raising a dequeue request together with an 8-bit subclass enable mask. The block serves the lowest enabled subclass that has an entry. A purge port removes every I/O entry that belongs to one subchannel, across all subclasses. The purge walks the subclasses one per cycle and raises a busy output while it runs. The has-work outputs are reductions of the pending state, so a processor can check for work without taking anything out.

Top module: `float_irq_queue`

## Requirements
- R1: The subclass of an injected I/O entry is the 3-bit field at bits 29:27 of its interrupt word. Injecting sets bit n of `io_pend` for subclass n, and the bit is visible in the cycle after the inject.
- R2: Each subclass is a last-in-first-out stack. A dequeue returns the newest entry still held in the served subclass. When a dequeue and an inject happen in the same cycle, the dequeue is applied first.
- R3: Each subclass holds at most 4 entries. An inject into a full subclass is dropped, and `io_ovf` is high for one cycle, in the cycle after the inject. A dequeue from that same subclass in the same cycle frees a slot first.
- R4: Bit n of `io_mask` enables subclass n. A dequeue serves the lowest-numbered subclass that is both enabled and non-empty. If there is none, `io_deq_none` pulses and `io_deq_valid` stays low.
- R5: A served dequeue drives `io_deq_valid` and the entry fields in the cycle after the request. Valid lasts for exactly one cycle per request.
- R6: Bit n of `io_pend` stays set while subclass n holds an entry. It clears when a dequeue or a purge empties that subclass.
- R7: A service inject ORs its parameter into the stored one and sets the service flag. A service dequeue while the flag is set returns the stored value on the next cycle, then clears both the value and the flag. A service dequeue while the flag is clear has no effect. If a dequeue and an inject happen in the same cycle, the dequeue returns the old value and the new parameter stays pending.
- R8: A machine-check inject sets `has_mchk` and an acknowledge clears it. If both arrive in the same cycle, the flag stays set.
- R9: An accepted purge removes, from every subclass, each entry whose id and number both match the key. The surviving entries keep their order. `purge_busy` is high for 8 cycles, and subclass n is updated at the end of the (n+1)th of those cycles.
- R10: A purge request is ignored when no I/O subclass is pending. `purge_busy` stays low in that case.
- R11: While `purge_busy` is high, I/O injects, I/O dequeues and new purge requests are ignored. Service and machine-check traffic continues as normal.
- R12: `has_svc`, `has_mchk`, `has_io` (any pending subclass enabled in `io_mask`) and `has_any` follow the current pending state combinationally.
- R13: A synchronous active-low reset empties all subclasses and clears every flag and pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_inj | input | 1 | Inject an I/O entry |
| io_inj_id | input | 16 | Subchannel id of the injected entry |
| io_inj_nr | input | 16 | Subchannel number of the injected entry |
| io_inj_parm | input | 32 | Interrupt parameter of the injected entry |
| io_inj_word | input | 32 | Interrupt word; bits 29:27 select the subclass |
| io_mask | input | 8 | Subclass enable mask for dequeue and has_io |
| io_deq_req | input | 1 | Request one I/O entry |
| io_deq_valid | output | 1 | Dequeued entry is valid (one cycle) |
| io_deq_none | output | 1 | Dequeue found no enabled pending subclass |
| io_deq_id | output | 16 | Dequeued subchannel id |
| io_deq_nr | output | 16 | Dequeued subchannel number |
| io_deq_parm | output | 32 | Dequeued interrupt parameter |
| io_deq_word | output | 32 | Dequeued interrupt word |
| io_ovf | output | 1 | An inject was dropped on a full subclass |
| svc_inj | input | 1 | Inject a service signal |
| svc_inj_parm | input | 32 | Service parameter to merge |
| svc_deq_req | input | 1 | Take the pending service signal |
| svc_deq_valid | output | 1 | Service value returned (one cycle) |
| svc_deq_parm | output | 32 | Returned service parameter |
| mchk_inj | input | 1 | Raise the machine-check condition |
| mchk_ack | input | 1 | Acknowledge the machine-check condition |
| purge_req | input | 1 | Start a purge by subchannel key |
| purge_id | input | 16 | Purge key: subchannel id |
| purge_nr | input | 16 | Purge key: subchannel number |
| purge_busy | output | 1 | Purge walk in progress |
| has_svc | output | 1 | Service signal pending |
| has_io | output | 1 | An enabled subclass is pending |
| has_mchk | output | 1 | Machine-check condition pending |
| has_any | output | 1 | Anything pending |
| io_pend | output | 8 | Per-subclass non-empty bits |

## Verification
The bench builds the block with its default parameters: eight subclasses, each 4 entries deep. With only four slots, a handful of injects into one subclass reaches the overflow and same-cycle free-slot cases. Purge keys are drawn from a very small id/number space, so purges often remove entries from several subclasses at once. Mixed mask patterns exercise the lowest-enabled-subclass choice together with the stack order.

// File: rtl/fiq_pkg.sv
// Shared widths and entry type for the pending interrupt queue.
// Assumes the subclass field of the interrupt word starts at CLASS_LSB.
package fiq_pkg;
    localparam int ID_W      = 16;
    localparam int NR_W      = 16;
    localparam int PARM_W    = 32;
    localparam int WORD_W    = 32;
    localparam int CLASS_LSB = 27;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [NR_W-1:0]   nr;
        logic [PARM_W-1:0] parm;
        logic [WORD_W-1:0] word;
    } fiq_ent_t;
endpackage

// File: rtl/fiq_stack.sv
// One subclass store: a bounded last-in-first-out stack with an in-place
// purge. Slot 0 holds the oldest entry and slot cnt-1 the newest.
// Assumes push, pop and purge are never combined with purge (the parent
// gates them). A pop and a push in the same cycle apply the pop first.
module fiq_stack
    import fiq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  fiq_ent_t        push_ent,
    input  logic            pop,
    input  logic            purge,
    input  logic [ID_W-1:0] key_id,
    input  logic [NR_W-1:0] key_nr,
    output fiq_ent_t        top_ent,
    output logic            nonempty,
    output logic            ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fiq_ent_t         mem  [DEPTH];
    fiq_ent_t         comp [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] after_pop;
    logic [CNT_W-1:0] kept_cnt;
    logic             push_ok;

    // Occupancy after a pop and whether the push still fits.
    always_comb begin
        after_pop = cnt_q - CNT_W'(pop);
        push_ok   = push && (after_pop < CNT_W'(DEPTH));
        ovf       = push && (after_pop == CNT_W'(DEPTH));
        nonempty  = (cnt_q != '0);
    end

    // Newest entry, or zero when the stack is empty.
    always_comb begin
        top_ent = '0;
        if (cnt_q != '0) begin
            top_ent = mem[AW'(cnt_q - CNT_W'(1))];
        end
    end

    // Compacted image with matching entries removed, order kept.
    always_comb begin
        int kept;
        kept = 0;
        for (int i = 0; i < DEPTH; i++) begin
            comp[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if ((i < int'(cnt_q)) &&
                !((mem[i].id == key_id) && (mem[i].nr == key_nr))) begin
                comp[AW'(kept)] = mem[i];
                kept = kept + 1;
            end
        end
        kept_cnt = CNT_W'(kept);
    end

    // Occupancy counter: reset, purge, or pop/push update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (purge) begin
            cnt_q <= kept_cnt;
        end else begin
            cnt_q <= after_pop + CNT_W'(push_ok);
        end
    end

    // Slot storage: compacted image on purge, new top on push.
    always_ff @(posedge clk) begin
        if (purge) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= comp[i];
            end
        end else if (push_ok) begin
            mem[AW'(after_pop)] <= push_ent;
        end
    end
endmodule

// File: rtl/fiq_pick.sv
// Fixed-priority picker: reports the lowest set request bit.
// Assumes IDX_W is wide enough to number N requests.
module fiq_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fiq_flags.sv
// Service and machine-check pending state. Service parameters are
// OR-merged until taken. A take applies before a same-cycle inject.
// Machine-check inject wins over a same-cycle acknowledge.
module fiq_flags #(
    parameter int PARM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_inj,
    input  logic [PARM_W-1:0] svc_inj_parm,
    input  logic              svc_deq_req,
    input  logic              mchk_inj,
    input  logic              mchk_ack,
    output logic              svc_pend,
    output logic              svc_deq_valid,
    output logic [PARM_W-1:0] svc_deq_parm,
    output logic              mchk_pend
);
    logic [PARM_W-1:0] svc_parm_q;
    logic              take;
    logic [PARM_W-1:0] parm_base;
    logic              pend_base;

    // State left after a take, before merging a new inject.
    always_comb begin
        take      = svc_deq_req && svc_pend;
        parm_base = take ? '0 : svc_parm_q;
        pend_base = take ? 1'b0 : svc_pend;
    end

    // Service flag, merged parameter and returned value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_pend      <= 1'b0;
            svc_parm_q    <= '0;
            svc_deq_valid <= 1'b0;
            svc_deq_parm  <= '0;
        end else begin
            svc_deq_valid <= take;
            if (take) begin
                svc_deq_parm <= svc_parm_q;
            end
            svc_parm_q <= svc_inj ? (parm_base | svc_inj_parm) : parm_base;
            svc_pend   <= svc_inj | pend_base;
        end
    end

    // Machine-check flag with inject priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchk_pend <= 1'b0;
        end else if (mchk_inj) begin
            mchk_pend <= 1'b1;
        end else if (mchk_ack) begin
            mchk_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/float_irq_queue.sv
// Pending floating interrupt store: per-subclass I/O stacks, service and
// machine-check flags, a subclass-walking purge and has-work reductions.
// Assumes NUM_CLASS is a power of two that matches the subclass field width.
module float_irq_queue
    import fiq_pkg::*;
#(
    parameter int NUM_CLASS = 8,
    parameter int DEPTH     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_inj,
    input  logic [ID_W-1:0]      io_inj_id,
    input  logic [NR_W-1:0]      io_inj_nr,
    input  logic [PARM_W-1:0]    io_inj_parm,
    input  logic [WORD_W-1:0]    io_inj_word,
    input  logic [NUM_CLASS-1:0] io_mask,
    input  logic                 io_deq_req,
    output logic                 io_deq_valid,
    output logic                 io_deq_none,
    output logic [ID_W-1:0]      io_deq_id,
    output logic [NR_W-1:0]      io_deq_nr,
    output logic [PARM_W-1:0]    io_deq_parm,
    output logic [WORD_W-1:0]    io_deq_word,
    output logic                 io_ovf,
    input  logic                 svc_inj,
    input  logic [PARM_W-1:0]    svc_inj_parm,
    input  logic                 svc_deq_req,
    output logic                 svc_deq_valid,
    output logic [PARM_W-1:0]    svc_deq_parm,
    input  logic                 mchk_inj,
    input  logic                 mchk_ack,
    input  logic                 purge_req,
    input  logic [ID_W-1:0]      purge_id,
    input  logic [NR_W-1:0]      purge_nr,
    output logic                 purge_busy,
    output logic                 has_svc,
    output logic                 has_io,
    output logic                 has_mchk,
    output logic                 has_any,
    output logic [NUM_CLASS-1:0] io_pend
);
    localparam int CLS_W = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1;

    logic                 io_ok;
    logic [CLS_W-1:0]     inj_cls;
    fiq_ent_t             inj_ent;
    logic                 sel_found;
    logic [CLS_W-1:0]     sel_cls;
    logic [NUM_CLASS-1:0] push_v, pop_v, purge_v, ovf_v;
    fiq_ent_t             tops [NUM_CLASS];
    logic [CLS_W-1:0]     pidx_q;
    logic [ID_W-1:0]      key_id_q;
    logic [NR_W-1:0]      key_nr_q;
    logic                 svc_pend;
    logic                 mchk_pend;

    // I/O side is frozen while the purge walk runs.
    always_comb begin
        io_ok   = !purge_busy;
        inj_cls = io_inj_word[CLASS_LSB +: CLS_W];
        inj_ent = '{id: io_inj_id, nr: io_inj_nr,
                    parm: io_inj_parm, word: io_inj_word};
    end

    fiq_pick #(.N(NUM_CLASS), .IDX_W(CLS_W)) u_pick (
        .req   (io_pend & io_mask),
        .found (sel_found),
        .idx   (sel_cls)
    );

    generate
        for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
            // Per-subclass strobes from the shared request ports.
            always_comb begin
                push_v[k]  = io_ok && io_inj && (inj_cls == CLS_W'(k));
                pop_v[k]   = io_ok && io_deq_req && sel_found &&
                             (sel_cls == CLS_W'(k));
                purge_v[k] = purge_busy && (pidx_q == CLS_W'(k));
            end

            fiq_stack #(.DEPTH(DEPTH)) u_stack (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (push_v[k]),
                .push_ent (inj_ent),
                .pop      (pop_v[k]),
                .purge    (purge_v[k]),
                .key_id   (key_id_q),
                .key_nr   (key_nr_q),
                .top_ent  (tops[k]),
                .nonempty (io_pend[k]),
                .ovf      (ovf_v[k])
            );
        end
    endgenerate

    // Purge sequencer: latch the key, then visit one subclass per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            purge_busy <= 1'b0;
            pidx_q     <= '0;
            key_id_q   <= '0;
            key_nr_q   <= '0;
        end else if (purge_busy) begin
            if (pidx_q == CLS_W'(NUM_CLASS - 1)) begin
                purge_busy <= 1'b0;
                pidx_q     <= '0;
            end else begin
                pidx_q <= pidx_q + CLS_W'(1);
            end
        end else if (purge_req && (io_pend != '0)) begin
            purge_busy <= 1'b1;
            pidx_q     <= '0;
            key_id_q   <= purge_id;
            key_nr_q   <= purge_nr;
        end
    end

    // Dequeue result and overflow pulses, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_deq_valid <= 1'b0;
            io_deq_none  <= 1'b0;
            io_ovf       <= 1'b0;
            io_deq_id    <= '0;
            io_deq_nr    <= '0;
            io_deq_parm  <= '0;
            io_deq_word  <= '0;
        end else begin
            io_deq_valid <= io_ok && io_deq_req && sel_found;
            io_deq_none  <= io_ok && io_deq_req && !sel_found;
            io_ovf       <= |ovf_v;
            if (io_ok && io_deq_req && sel_found) begin
                io_deq_id   <= tops[sel_cls].id;
                io_deq_nr   <= tops[sel_cls].nr;
                io_deq_parm <= tops[sel_cls].parm;
                io_deq_word <= tops[sel_cls].word;
            end
        end
    end

    fiq_flags #(.PARM_W(PARM_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .svc_inj       (svc_inj),
        .svc_inj_parm  (svc_inj_parm),
        .svc_deq_req   (svc_deq_req),
        .mchk_inj      (mchk_inj),
        .mchk_ack      (mchk_ack),
        .svc_pend      (svc_pend),
        .svc_deq_valid (svc_deq_valid),
        .svc_deq_parm  (svc_deq_parm),
        .mchk_pend     (mchk_pend)
    );

    // Has-work reductions of the pending state.
    always_comb begin
        has_svc  = svc_pend;
        has_mchk = mchk_pend;
        has_io   = |(io_pend & io_mask);
        has_any  = svc_pend || mchk_pend || (io_pend != '0);
    end
endmodule

// File: rtl/fiq_checker.sv
// Temporal checks on the port behaviour of float_irq_queue; bound below.
// Assumes it is connected by name to the ports of the top module.
module fiq_checker #(
    parameter int NUM_CLASS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_inj,
    input logic                 io_deq_req,
    input logic                 io_deq_valid,
    input logic                 io_deq_none,
    input logic                 io_ovf,
    input logic                 purge_req,
    input logic                 purge_busy,
    input logic [NUM_CLASS-1:0] io_pend,
    input logic                 svc_deq_req,
    input logic                 svc_deq_valid,
    input logic                 has_svc,
    input logic                 mchk_inj,
    input logic                 has_mchk
);
    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_ovf |-> $past(io_inj && !purge_busy));

    assert_deq_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_deq_valid && io_deq_none));

    assert_deq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_deq_valid |-> $past(io_deq_req && !purge_busy));

    assert_svc_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_deq_valid |-> $past(svc_deq_req && has_svc));

    assert_mchk_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_inj |=> has_mchk);

    assert_purge_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(purge_busy) |-> $past(purge_req && (io_pend != '0)));

    assert_busy_no_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_busy && io_inj) |=> !io_ovf);
endmodule

bind float_irq_queue fiq_checker #(.NUM_CLASS(NUM_CLASS)) u_chk (.*);

// File: tb/sim_float_irq_queue.sv
module sim_float_irq_queue;
    typedef struct packed {
        logic [15:0] id;
        logic [15:0] nr;
        logic [31:0] parm;
        logic [31:0] word;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_inj = 1'b0;
    logic [15:0] io_inj_id = '0;
    logic [15:0] io_inj_nr = '0;
    logic [31:0] io_inj_parm = '0;
    logic [31:0] io_inj_word = '0;
    logic [7:0]  io_mask = '0;
    logic        io_deq_req = 1'b0;
    logic        io_deq_valid, io_deq_none, io_ovf;
    logic [15:0] io_deq_id, io_deq_nr;
    logic [31:0] io_deq_parm, io_deq_word;
    logic        svc_inj = 1'b0;
    logic [31:0] svc_inj_parm = '0;
    logic        svc_deq_req = 1'b0;
    logic        svc_deq_valid;
    logic [31:0] svc_deq_parm;
    logic        mchk_inj = 1'b0, mchk_ack = 1'b0;
    logic        purge_req = 1'b0;
    logic [15:0] purge_id = '0, purge_nr = '0;
    logic        purge_busy, has_svc, has_io, has_mchk, has_any;
    logic [7:0]  io_pend;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    float_irq_queue u0 (.*);

    // Reference model state
    ent_t        mq [8][$];
    bit          m_busy = 0;
    int          m_pidx = 0;
    logic [15:0] m_kid = '0, m_knr = '0;
    bit          m_svc = 0;
    logic [31:0] m_svp = '0;
    bit          m_mchk = 0;
    bit          e_valid = 0, e_none = 0, e_ovf = 0, e_sv = 0;
    ent_t        e_ent = '0;
    logic [31:0] e_svp = '0;
    logic [7:0]  pb;
    int          fk;
    ent_t        ne;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_pend();
        logic [7:0] p;
        for (int k = 0; k < 8; k++) p[k] = (mq[k].size() > 0);
        return p;
    endfunction

    // Model update on every edge, then compare shortly after
    always @(posedge clk) begin
        e_valid = 0; e_none = 0; e_ovf = 0; e_sv = 0;
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) mq[k].delete();
            m_busy = 0; m_pidx = 0; m_svc = 0; m_svp = '0; m_mchk = 0;
        end else begin
            pb = m_pend();
            if (m_busy) begin
                for (int i = mq[m_pidx].size() - 1; i >= 0; i--)
                    if (mq[m_pidx][i].id == m_kid && mq[m_pidx][i].nr == m_knr)
                        mq[m_pidx].delete(i);
                if (m_pidx == 7) m_busy = 0;
                m_pidx = (m_pidx + 1) % 8;
            end else begin
                if (io_deq_req) begin
                    fk = -1;
                    for (int k = 7; k >= 0; k--)
                        if (mq[k].size() > 0 && io_mask[k]) fk = k;
                    if (fk >= 0) begin e_ent = mq[fk].pop_front(); e_valid = 1; end
                    else e_none = 1;
                end
                if (io_inj) begin
                    fk = int'(io_inj_word[29:27]);
                    ne = '{id: io_inj_id, nr: io_inj_nr, parm: io_inj_parm, word: io_inj_word};
                    if (mq[fk].size() < 4) mq[fk].push_front(ne);
                    else e_ovf = 1;
                end
                if (purge_req && pb != 0) begin
                    m_busy = 1; m_pidx = 0; m_kid = purge_id; m_knr = purge_nr;
                end
            end
            if (svc_deq_req && m_svc) begin
                e_sv = 1; e_svp = m_svp; m_svp = '0; m_svc = 0;
            end
            if (svc_inj) begin m_svp = m_svp | svc_inj_parm; m_svc = 1; end
            if (mchk_inj) m_mchk = 1;
            else if (mchk_ack) m_mchk = 0;
        end
        #1;
        chk("R6 io_pend", io_pend, m_pend());
        chk("R12 has_svc", has_svc, m_svc);
        chk("R8 has_mchk", has_mchk, m_mchk);
        chk("R12 has_io", has_io, |(m_pend() & io_mask));
        chk("R12 has_any", has_any, m_svc || m_mchk || (m_pend() != 0));
        chk("R9 purge_busy", purge_busy, m_busy);
        chk("R5 io_deq_valid", io_deq_valid, e_valid);
        chk("R4 io_deq_none", io_deq_none, e_none);
        chk("R3 io_ovf", io_ovf, e_ovf);
        chk("R7 svc_deq_valid", svc_deq_valid, e_sv);
        if (e_valid)
            chk("R2 dequeued entry", {io_deq_id, io_deq_nr, io_deq_parm, io_deq_word}, e_ent);
        if (e_sv)
            chk("R7 service parm", svc_deq_parm, e_svp);
    end

    task automatic inj(input int cls, input logic [15:0] id, input logic [15:0] nr, input logic [31:0] parm);
        io_inj = 1; io_inj_id = id; io_inj_nr = nr; io_inj_parm = parm;
        io_inj_word = {2'b01, 3'(cls), 27'(parm ^ 32'h5a5)};
        @(negedge clk);
        io_inj = 0;
    endtask

    task automatic deq(input logic [7:0] mask);
        io_deq_req = 1; io_mask = mask;
        @(negedge clk);
        io_deq_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13: reset state
        chk("R13 reset pend", io_pend, 8'h00);
        chk("R13 reset has_any", has_any, 1'b0);
        chk("R13 reset busy", purge_busy, 1'b0);

        // R10: purge with nothing pending is ignored
        purge_req = 1; @(negedge clk); purge_req = 0;
        chk("R10 busy stays low", purge_busy, 1'b0);

        // R1: subclass field selects the pending bit
        inj(5, 16'h11, 16'h1, 32'hA0);
        chk("R1 class 5 pending", io_pend, 8'h20);

        // R2: stack order
        inj(2, 16'h1, 16'h1, 32'h1);
        inj(2, 16'h2, 16'h1, 32'h2);
        inj(2, 16'h3, 16'h1, 32'h3);
        io_deq_req = 1; io_mask = 8'h04; @(negedge clk); io_deq_req = 0;
        chk("R5 valid one cycle after request", io_deq_valid, 1'b1);
        chk("R2 newest first", io_deq_parm, 32'h3);
        @(negedge clk);
        chk("R5 valid drops", io_deq_valid, 1'b0);

        // R4: lowest enabled subclass served, mask respected
        deq(8'h20);
        chk("R4 class 5 served", io_deq_parm, 32'hA0);
        chk("R6 class 5 cleared", io_pend[5], 1'b0);
        deq(8'h01);
        chk("R4 nothing enabled", io_deq_none, 1'b1);

        // R3: overflow on a full subclass
        for (int i = 0; i < 4; i++) inj(3, 16'h7, 16'h2, 32'h30 + i);
        chk("R3 no overflow at four", io_ovf, 1'b0);
        inj(3, 16'h7, 16'h2, 32'h3F);
        chk("R3 fifth dropped", io_ovf, 1'b1);

        // R9/R11: purge key (7,2) empties class 3; inject during busy ignored
        purge_req = 1; purge_id = 16'h7; purge_nr = 16'h2; @(negedge clk); purge_req = 0;
        chk("R9 busy raised", purge_busy, 1'b1);
        inj(0, 16'h9, 16'h9, 32'h99);
        idle(7);
        chk("R9 busy ended", purge_busy, 1'b0);
        chk("R11 inject during purge ignored", io_pend, 8'h04);

        // R7: service merge, take, same-cycle take and inject
        svc_inj = 1; svc_inj_parm = 32'h0F; @(negedge clk);
        svc_inj_parm = 32'hF0; @(negedge clk); svc_inj = 0;
        svc_deq_req = 1; svc_inj = 1; svc_inj_parm = 32'h100; @(negedge clk);
        svc_deq_req = 0; svc_inj = 0;
        chk("R7 merged value returned", svc_deq_parm, 32'hFF);
        chk("R7 new inject kept", has_svc, 1'b1);

        // R8: inject wins over same-cycle ack
        mchk_inj = 1; mchk_ack = 1; @(negedge clk); mchk_inj = 0;
        chk("R8 inject wins", has_mchk, 1'b1);
        @(negedge clk); mchk_ack = 0;
        chk("R8 ack clears", has_mchk, 1'b0);

        // Mixed traffic, compared each cycle against the model
        for (int c = 0; c < 4000; c++) begin
            io_inj = ($urandom % 3) == 0;
            io_inj_id = 16'($urandom % 3);
            io_inj_nr = 16'($urandom % 2);
            io_inj_parm = $urandom;
            io_inj_word = $urandom;
            io_deq_req = ($urandom % 4) == 0;
            io_mask = 8'($urandom);
            svc_inj = ($urandom % 5) == 0;
            svc_inj_parm = $urandom;
            svc_deq_req = ($urandom % 5) == 0;
            mchk_inj = ($urandom % 7) == 0;
            mchk_ack = ($urandom % 6) == 0;
            purge_req = ($urandom % 23) == 0;
            purge_id = 16'($urandom % 3);
            purge_nr = 16'($urandom % 2);
            @(negedge clk);
        end
        io_inj = 0; io_deq_req = 0; svc_inj = 0; svc_deq_req = 0;
        mchk_inj = 0; mchk_ack = 0; purge_req = 0;
        idle(12);

        // R13: reset empties everything
        rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R13 reset clears pend", io_pend, 8'h00);
        chk("R13 reset clears any", has_any, 1'b0);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule